// File: doc/BRIEF.md
# Configurable Storage Macrocell Stage

This block is the storage-and-output stage of a programmable logic cell, replicated across a small vector of bits that share one set of configuration bits. A sum-of-products result enters on `sumTerm`. A two-bit mode word decides how that result is kept. It can pass straight through as combinational logic. It can be captured by a D flip-flop, or folded into a T flip-flop that toggles on a one. Finally, it can be held by a latch that is transparent while the shared clock/enable line is low. An active-high asynchronous reset clears every stored value.

A cell-type bit marks the stage as pin-facing or buried. A pin-facing cell drives its pin path and may invert it through a polarity bit. A buried cell keeps its pin path quiet and serves only as internal feedback. The feedback path always carries the selected internal value without inversion. The polarity is applied after the mode selection, so it affects the pin path only.

Top module: `macrocell_stage`

## Requirements
- R1: With mode 2'b00 (combinational), `feedback` equals `sumTerm` at all times, with no clock involved.
- R2: With mode 2'b01 (D register), the stored value takes `sumTerm` on a rising edge of `clkLe` only. At a falling edge, and while `clkLe` is steady, it holds.
- R3: With mode 2'b10 (T register), at a rising edge each stored bit toggles where `sumTerm` is 1 and keeps its value where `sumTerm` is 0. It holds at all other times.
- R4: With mode 2'b11 (latch), the stored value follows `sumTerm` while `clkLe` is 0 and holds while `clkLe` is 1.
- R5: With `isOutput` = 1, `pinOut` equals the selected value, with every bit inverted when `invertPol` = 1.
- R6: With `isOutput` = 0 (buried), `pinOut` is all zeros and `invertPol` has no effect on either output.
- R7: `feedback` always carries the uninverted selected value, whatever `invertPol` is.
- R8: While `rst` is 1, both the flip-flop state and the latch state are 0, without waiting for a clock edge. In either register mode and in latch mode, `feedback` then reads 0.
- R9: The flip-flop state holds while the mode is neither D nor T, and the latch state holds while the mode is not latch. Switching back to a mode therefore shows the value that mode last stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkLe | input | 1 | Clock for the register modes; transparent-low enable for the latch mode |
| rst | input | 1 | Asynchronous reset, active high |
| sumTerm | input | WIDTH | Sum-of-products input, one bit per cell |
| modeSel | input | 2 | 00 combinational, 01 D register, 10 T register, 11 latch |
| isOutput | input | 1 | 1 marks a pin-facing cell, 0 a buried cell |
| invertPol | input | 1 | Inverts the pin path of a pin-facing cell |
| pinOut | output | WIDTH | Pin-path value |
| feedback | output | WIDTH | Internal feedback value, never inverted |

## Verification
The assertions assume several things about the inputs. The data and configuration inputs change only while `clkLe` is high and well clear of its rising edge. Any switch into latch mode is made at least one low phase before the next rising edge. Reset is released away from a rising edge. The bench meets these assumptions by driving every input 5 ns after a rising edge of the 50 MHz `clkLe`, which is in the high phase, when the latch is closed. It holds those inputs through the following falling edge and the next rising edge, and it raises and drops reset at the same point in the cycle. Each applied step is checked three times: just after the inputs change with the latch closed, during the open low phase, and after the capturing rising edge. This separates edge-triggered from level-sensitive behaviour.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_DREG  = 2'b01,
    MODE_TREG  = 2'b10,
    MODE_LATCH = 2'b11
  } cellMode_e;

  typedef struct packed {
    logic flopLoad;    // D capture at rising edge
    logic flopToggle;  // T fold at rising edge
    logic latchArm;    // latch may open while enable is low
    logic selFlop;     // output mux picks flop state
    logic selLatch;    // output mux picks latch state
    logic pinDrive;    // pin path is live
    logic polInvert;   // invert pin path
  } ctlStrobes_t;

endpackage

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
(
  input  logic [1:0]  modeSel,
  input  logic        isOutput,
  input  logic        invertPol,
  output ctlStrobes_t strobes
);

  cellMode_e modeNow;

  always_comb begin
    modeNow = cellMode_e'(modeSel);
    strobes = '0;
    unique case (modeNow)
      MODE_COMB:  ;
      MODE_DREG:  begin strobes.flopLoad   = 1'b1; strobes.selFlop = 1'b1; end
      MODE_TREG:  begin strobes.flopToggle = 1'b1; strobes.selFlop = 1'b1; end
      MODE_LATCH: begin strobes.latchArm   = 1'b1; strobes.selLatch = 1'b1; end
      default:    ;
    endcase
    strobes.pinDrive  = isOutput;
    // polarity only exists on pin-facing cells
    strobes.polInvert = isOutput & invertPol;
  end

  always_comb begin
    assert ($onehot0({strobes.flopLoad, strobes.flopToggle, strobes.latchArm}))
      else $error("p_one_store_r9: more than one storage strobe active");
  end

endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clkLe,
  input  logic             rst,
  input  logic [WIDTH-1:0] sumTerm,
  input  ctlStrobes_t      strobes,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] feedback
);

  logic [WIDTH-1:0] flopQ;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] cellValue;

  // edge-triggered element shared by D and T modes
  always_ff @(posedge clkLe or posedge rst) begin
    if (rst)                     flopQ <= '0;
    else if (strobes.flopLoad)   flopQ <= sumTerm;
    else if (strobes.flopToggle) flopQ <= flopQ ^ sumTerm;
  end

  // level-sensitive element, open while enable is low
  always_latch begin
    if (rst)                            latchQ <= '0;
    else if (strobes.latchArm && !clkLe) latchQ <= sumTerm;
  end

  always_comb begin
    if (strobes.selFlop)       cellValue = flopQ;
    else if (strobes.selLatch) cellValue = latchQ;
    else                       cellValue = sumTerm;
  end

  assign feedback = cellValue;
  assign pinOut   = strobes.pinDrive ? (cellValue ^ {WIDTH{strobes.polInvert}}) : '0;

  p_dreg_capture_r2: assert property (@(posedge clkLe) disable iff (rst)
    ($past(strobes.flopLoad) && !$past(rst)) |-> flopQ == $past(sumTerm))
    else $error("p_dreg_capture_r2");

  p_treg_toggle_r3: assert property (@(posedge clkLe) disable iff (rst)
    ($past(strobes.flopToggle) && !$past(rst)) |-> flopQ == ($past(flopQ) ^ $past(sumTerm)))
    else $error("p_treg_toggle_r3");

  p_flop_hold_r9: assert property (@(posedge clkLe) disable iff (rst)
    (!$past(strobes.flopLoad) && !$past(strobes.flopToggle) && !$past(rst))
      |-> $stable(flopQ))
    else $error("p_flop_hold_r9");

  p_latch_follow_r4: assert property (@(posedge clkLe) disable iff (rst)
    (strobes.latchArm && $past(strobes.latchArm) && !$past(rst)) |-> latchQ == sumTerm)
    else $error("p_latch_follow_r4");

endmodule

// File: rtl/macrocell_stage.sv
`timescale 1ns/1ps
module macrocell_stage
  import mc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clkLe,
  input  logic             rst,
  input  logic [WIDTH-1:0] sumTerm,
  input  logic [1:0]       modeSel,
  input  logic             isOutput,
  input  logic             invertPol,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] feedback
);

  ctlStrobes_t strobes;

  mc_ctrl i_ctrl (
    .modeSel   (modeSel),
    .isOutput  (isOutput),
    .invertPol (invertPol),
    .strobes   (strobes)
  );

  mc_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clkLe    (clkLe),
    .rst      (rst),
    .sumTerm  (sumTerm),
    .strobes  (strobes),
    .pinOut   (pinOut),
    .feedback (feedback)
  );

  p_pin_polarity_r5: assert property (@(posedge clkLe) disable iff (rst)
    isOutput |-> pinOut == (feedback ^ {WIDTH{invertPol}}))
    else $error("p_pin_polarity_r5");

  p_buried_quiet_r6: assert property (@(posedge clkLe) disable iff (rst)
    !isOutput |-> pinOut == '0)
    else $error("p_buried_quiet_r6");

  p_comb_pass_r1: assert property (@(posedge clkLe) disable iff (rst)
    (modeSel == 2'b00) |-> feedback == sumTerm)
    else $error("p_comb_pass_r1");

endmodule

// File: tb/test_macrocell_stage.sv
`timescale 1ns/1ps
module test_macrocell_stage;

  localparam int W = 4;

  logic         clkLe = 1'b0;
  logic         rst;
  logic [W-1:0] sumTerm;
  logic [1:0]   modeSel;
  logic         isOutput;
  logic         invertPol;
  logic [W-1:0] pinOut;
  logic [W-1:0] feedback;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  logic [W-1:0] modelFlop;
  logic [W-1:0] modelLatch;

  macrocell_stage #(.WIDTH(W)) i_macrocell_stage (
    .clkLe(clkLe), .rst(rst), .sumTerm(sumTerm), .modeSel(modeSel),
    .isOutput(isOutput), .invertPol(invertPol), .pinOut(pinOut), .feedback(feedback)
  );

  always #10 clkLe = ~clkLe;

  task automatic check(input logic [W-1:0] expVal, input string req);
    logic [W-1:0] expPin;
    expPin = isOutput ? (expVal ^ {W{invertPol}}) : '0;
    vectors++;
    if (feedback !== expVal || pinOut !== expPin) begin
      misses++;
      $display("FAIL %s mode=%0d out=%0b inv=%0b: feedback=%h pin=%h expected feedback=%h pin=%h",
               req, modeSel, isOutput, invertPol, feedback, pinOut, expVal, expPin);
    end
  endtask

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b00:   return "R1 R5 R6 R7";
      2'b01:   return "R2 R5 R6 R7 R9";
      2'b10:   return "R3 R5 R6 R7 R9";
      default: return "R4 R5 R6 R7 R9";
    endcase
  endfunction

  // Called at rising edge + 5 ns; returns at the next rising edge + 5 ns.
  task automatic step(input logic [W-1:0] d, input logic [1:0] m, input logic o, input logic v);
    logic [W-1:0] held;
    sumTerm = d; modeSel = m; isOutput = o; invertPol = v;
    #2;
    // high phase: latch closed, no edge yet
    case (m)
      2'b00:   held = d;
      2'b11:   held = modelLatch;
      default: held = modelFlop;
    endcase
    check(held, reqOf(m));
    @(negedge clkLe); #5;
    // low phase: latch open, flop untouched by the falling edge
    if (m == 2'b11) modelLatch = d;
    case (m)
      2'b00:   held = d;
      2'b11:   held = modelLatch;
      default: held = modelFlop;
    endcase
    check(held, reqOf(m));
    @(posedge clkLe); #5;
    if (m == 2'b01) modelFlop = d;
    else if (m == 2'b10) modelFlop = modelFlop ^ d;
    case (m)
      2'b00:   held = d;
      2'b11:   held = modelLatch;
      default: held = modelFlop;
    endcase
    check(held, reqOf(m));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sumTerm = 4'hA; modeSel = 2'b01; isOutput = 1'b1; invertPol = 1'b0;
    modelFlop = '0; modelLatch = '0;
    repeat (3) @(posedge clkLe);
    #5;
    check('0, "R8 reset D mode");
    modeSel = 2'b11; #2;
    check('0, "R8 reset latch mode");
    @(negedge clkLe); #5;
    check('0, "R8 reset latch held while open");
    @(posedge clkLe); #5;
    rst = 1'b0;

    // configuration sweep
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int v = 0; v < 2; v++)
          for (int k = 0; k < 8; k++)
            step(W'((k * 7 + m * 3 + o + 5 * v) & 15), 2'(m), 1'(o), 1'(v));

    // rotating modes to exercise state retention across switches
    for (int k = 0; k < 32; k++)
      step(W'((k * 11 + 3) & 15), 2'(k % 4), 1'((k / 4) % 2), 1'((k / 8) % 2));

    // asynchronous reset mid-run
    step(4'hF, 2'b10, 1'b1, 1'b0);
    step(4'h6, 2'b11, 1'b1, 1'b1);
    modeSel = 2'b10; isOutput = 1'b1; invertPol = 1'b1;
    rst = 1'b1; #2;
    modelFlop = '0; modelLatch = '0;
    check('0, "R8 async clear flop");
    modeSel = 2'b11; #2;
    check('0, "R8 async clear latch");
    @(posedge clkLe); #5;
    rst = 1'b0;
    step(4'h9, 2'b01, 1'b0, 1'b1);
    step(4'h5, 2'b10, 1'b1, 1'b1);
    step(4'hC, 2'b11, 1'b0, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule